// File: doc/BRIEF.md
# Multiplexed Bus Master Sequencer

This block is the master side of a synchronous parallel bus where address and data share one set of wires. A local client hands it one request: a command code, a start address, a word count and a set of byte enables. The block then asks for the bus and waits for the grant. It drives one address cycle that carries the command, then runs data cycles until the burst is complete or the target stops it. Each pin is split into an output value, an output enable and, where the bus is read, an input.

During a write, the block fetches the outgoing word through an index. It shows the index of the next word, and the client returns that word on the same cycle. During a read, each word that moves appears one cycle later on a local output with a strobe. The block sorts every transaction into one of four results and reports the result along with the number of words moved. It does not retry by itself. After a retry or a disconnect, the client has to issue a new request, which asks for the bus again.

Top module: `bus_master_seq`

## Requirements
- R1: During and right after reset, `req_n_o` and `irdy_n_o` are high, every output enable is low, `done` and `rd_valid` are low.
- R2: An accepted request (`req_valid` high while idle) drives `req_n_o` low in the next cycle. It stays low until `gnt_n_i` is sampled low on a rising edge. The address cycle follows in the next cycle, and there `req_n_o` is high again.
- R3: In the address cycle `frame_n_o` is low, `ad_o` carries the request address and `cbe_o` carries the command, with all three enabled.
- R4: In every data cycle `irdy_n_o` is low and driven. `cbe_o` is the inverse of the active-high `req_be` (bit 3 covers AD[31:24], bit 0 covers AD[7:0]). On a read, `ad_oe` is low from the first data cycle on, which leaves a turnaround cycle.
- R5: A word moves only on a rising edge where `trdy_n_i` is low during a data cycle. On a read, that word shows up on `rd_data` with `rd_valid` high during the following cycle.
- R6: `frame_n_o` is driven high during the final data cycle, while `irdy_n_o` is still low. For a one-word request, this is the first data cycle.
- R7: The cycle after the transaction ends drives `frame_n_o` and `irdy_n_o` high. It releases AD and C/BE and raises `done`. In the next cycle all bus enables are low.
- R8: If `stop_n_i` is sampled low before any word has moved, the result is retry (code 1) with a count of 0.
- R9: If `stop_n_i` is sampled low once at least one word has moved, the result is disconnect (code 2), and the count includes any word that moved on that same edge.
- R10: If `devsel_n_i` has not been sampled low by the edge that ends the fifth data cycle, the result is master abort (code 3).
- R11: A burst that runs to its full length reports complete (code 0) with a count equal to the length. A length of 0 is treated as 1.
- R12: Command bit 0 selects the direction: 1 is a write, so `ad_o` carries `wr_data` for word `wr_idx`, and 0 is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, accepted while idle |
| req_cmd | input | 4 | Command code for the address cycle |
| req_addr | input | DW | Start address |
| req_len | input | LEN_W | Words in the burst (0 treated as 1) |
| req_be | input | 4 | Byte enables, active high |
| wr_data | input | DW | Write word for index `wr_idx` |
| wr_idx | output | LEN_W | Index of the word to be written next |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | DW | Read word |
| done | output | 1 | High for the single end cycle |
| end_kind | output | 2 | 0 complete, 1 retry, 2 disconnect, 3 master abort |
| end_count | output | LEN_W | Words moved in the last transaction |
| req_n_o | output | 1 | Bus request, active low |
| gnt_n_i | input | 1 | Bus grant, active low |
| frame_n_o | output | 1 | Frame value |
| frame_oe | output | 1 | Frame drive enable |
| irdy_n_o | output | 1 | Initiator ready value |
| irdy_oe | output | 1 | Initiator ready drive enable |
| ad_o | output | DW | Address/data out |
| ad_oe | output | 1 | Address/data drive enable |
| ad_i | input | DW | Address/data in |
| cbe_o | output | 4 | Command / byte-enable value, active low enables |
| cbe_oe | output | 1 | Command / byte-enable drive enable |
| trdy_n_i | input | 1 | Target ready, active low |
| stop_n_i | input | 1 | Target stop, active low |
| devsel_n_i | input | 1 | Device select, active low |

## Verification
The bench checks every bus output and local output on every clock, so a wrong phase state shows up at the pins in the same cycle. For example, a wrong word count shows up as `frame_n_o` rising one cycle early or late, or as `wr_idx` pointing at the wrong word. If the device-select watch is wrong, the transaction ends in the wrong data cycle or with the wrong result. If the retry/disconnect split is wrong, the error appears on `end_kind` in the single cycle where `done` is high. The stimulus covers wait states from the target, late device select, a delayed grant, stop on the same edge as a transfer, and zero-length requests.

// File: rtl/bus_master_pkg.sv
package bus_master_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_TURN
    } seq_state_e;

    typedef enum logic [1:0] {
        END_OK    = 2'd0,
        END_RETRY = 2'd1,
        END_DISC  = 2'd2,
        END_ABORT = 2'd3
    } end_kind_e;

    typedef struct packed {
        logic [3:0] cmd;
        logic [3:0] be;
    } req_ctl_t;

    function automatic logic cmd_writes(input logic [3:0] cmd);
        return cmd[0];
    endfunction

endpackage

// File: rtl/bus_beat_track.sv
module bus_beat_track #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             xfer,
    output logic [LEN_W-1:0] count,
    output logic             last
);
    logic [LEN_W-1:0] left_q;
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            left_q <= (len == '0) ? LEN_W'(1) : len;
            cnt_q  <= '0;
        end else if (xfer) begin
            left_q <= left_q - LEN_W'(1);
            cnt_q  <= cnt_q + LEN_W'(1);
        end
    end

    assign count = cnt_q;
    assign last  = (left_q == LEN_W'(1));

    // R11
    beat_never_under_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer && !load) |-> (left_q != '0));
endmodule

// File: rtl/bus_sel_watch.sv
module bus_sel_watch #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic active,
    input  logic devsel_n,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cyc_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cyc_q  <= '0;
            seen_q <= 1'b0;
        end else if (active) begin
            if (!devsel_n) seen_q <= 1'b1;
            if (cyc_q != CW'(LIMIT - 1)) cyc_q <= cyc_q + CW'(1);
        end
    end

    assign expired = active && !seen_q && devsel_n && (cyc_q == CW'(LIMIT - 1));

    // R10
    seen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !clear) |=> seen_q);
endmodule

// File: rtl/bus_master_seq.sv
module bus_master_seq
    import bus_master_pkg::*;
#(
    parameter int DW        = 32,
    parameter int LEN_W     = 8,
    parameter int SEL_LIMIT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [3:0]       req_cmd,
    input  logic [DW-1:0]    req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [3:0]       req_be,
    input  logic [DW-1:0]    wr_data,
    output logic [LEN_W-1:0] wr_idx,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             done,
    output logic [1:0]       end_kind,
    output logic [LEN_W-1:0] end_count,
    output logic             req_n_o,
    input  logic             gnt_n_i,
    output logic             frame_n_o,
    output logic             frame_oe,
    output logic             irdy_n_o,
    output logic             irdy_oe,
    output logic [DW-1:0]    ad_o,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_i,
    output logic [3:0]       cbe_o,
    output logic             cbe_oe,
    input  logic             trdy_n_i,
    input  logic             stop_n_i,
    input  logic             devsel_n_i
);
    seq_state_e       state_q, state_d;
    req_ctl_t         ctl_q;
    logic [DW-1:0]    addr_q;
    logic [LEN_W-1:0] len_q;
    end_kind_e        kind_q, kind_d;
    logic [LEN_W-1:0] ecnt_q, ecnt_d;
    logic             rdv_q;
    logic [DW-1:0]    rdd_q;

    logic             in_addr, in_data, in_turn;
    logic             xfer, stop_hit, sel_expired, last;
    logic [LEN_W-1:0] beats;

    assign in_addr  = (state_q == ST_ADDR);
    assign in_data  = (state_q == ST_DATA);
    assign in_turn  = (state_q == ST_TURN);
    assign xfer     = in_data && !trdy_n_i;
    assign stop_hit = in_data && !stop_n_i;

    bus_beat_track #(.LEN_W(LEN_W)) u_beats (
        .clk   (clk),
        .rst   (rst),
        .load  (in_addr),
        .len   (len_q),
        .xfer  (xfer),
        .count (beats),
        .last  (last)
    );

    bus_sel_watch #(.LIMIT(SEL_LIMIT)) u_watch (
        .clk      (clk),
        .rst      (rst),
        .clear    (in_addr),
        .active   (in_data),
        .devsel_n (devsel_n_i),
        .expired  (sel_expired)
    );

    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        ecnt_d  = ecnt_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_REQ;
            ST_REQ:  if (!gnt_n_i)  state_d = ST_ADDR;
            ST_ADDR: state_d = ST_DATA;
            ST_DATA: begin
                if (stop_hit) begin
                    kind_d  = (beats == '0 && !xfer) ? END_RETRY : END_DISC;
                    ecnt_d  = beats + LEN_W'(xfer);
                    state_d = ST_TURN;
                end else if (xfer && last) begin
                    kind_d  = END_OK;
                    ecnt_d  = beats + LEN_W'(1);
                    state_d = ST_TURN;
                end else if (sel_expired) begin
                    kind_d  = END_ABORT;
                    ecnt_d  = beats;
                    state_d = ST_TURN;
                end
            end
            ST_TURN: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            kind_q  <= END_OK;
            ecnt_q  <= '0;
            rdv_q   <= 1'b0;
            rdd_q   <= '0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            ecnt_q  <= ecnt_d;
            rdv_q   <= xfer && !cmd_writes(ctl_q.cmd);
            if (xfer) rdd_q <= ad_i;
            if (state_q == ST_IDLE && req_valid) begin
                ctl_q.cmd <= req_cmd;
                ctl_q.be  <= req_be;
                addr_q    <= req_addr;
                len_q     <= req_len;
            end
        end
    end

    assign req_n_o   = (state_q != ST_REQ);
    assign frame_oe  = in_addr || in_data || in_turn;
    assign frame_n_o = !(in_addr || (in_data && !last));
    assign irdy_oe   = in_data || in_turn;
    assign irdy_n_o  = !in_data;
    assign ad_oe     = in_addr || (in_data && cmd_writes(ctl_q.cmd));
    assign ad_o      = in_addr ? addr_q : wr_data;
    assign cbe_oe    = in_addr || in_data;
    assign cbe_o     = in_addr ? ctl_q.cmd : ~ctl_q.be;
    assign wr_idx    = beats;
    assign rd_valid  = rdv_q;
    assign rd_data   = rdd_q;
    assign done      = in_turn;
    assign end_kind  = kind_q;
    assign end_count = ecnt_q;

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_n_o && gnt_n_i) |=> !req_n_o);
    // R3
    addr_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_oe) |-> (!frame_n_o && ad_oe && cbe_oe && req_n_o));
    // R4
    irdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irdy_oe && !irdy_n_o && trdy_n_i && stop_n_i && !sel_expired) |=> (irdy_oe && !irdy_n_o));
    // R5
    rd_from_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!trdy_n_i && !irdy_n_o && irdy_oe));
    // R6
    frame_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(frame_n_o) && frame_oe) |-> (!irdy_n_o || done));
    // R7
    end_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (irdy_oe && irdy_n_o && frame_n_o && !ad_oe && !cbe_oe));
    // R8
    retry_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && end_kind == END_RETRY) |-> (end_count == '0));
endmodule

// File: tb/bus_master_seq_bench.sv
module bus_master_seq_bench;
    localparam int DW = 32;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [3:0]    req_cmd = '0;
    logic [DW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [3:0]    req_be = '0;
    logic [DW-1:0] wr_data;
    logic [LW-1:0] wr_idx;
    logic          rd_valid, done;
    logic [DW-1:0] rd_data, ad_o;
    logic [1:0]    end_kind;
    logic [LW-1:0] end_count;
    logic          req_n_o, frame_n_o, frame_oe, irdy_n_o, irdy_oe, ad_oe, cbe_oe;
    logic [3:0]    cbe_o;
    logic          gnt_n_i = 1'b1, trdy_n_i = 1'b1, stop_n_i = 1'b1, devsel_n_i = 1'b1;
    logic [DW-1:0] ad_i = '0;

    always #2.5 clk = ~clk;

    assign wr_data = 32'hC0DE_0000 + {24'd0, wr_idx};

    bus_master_seq #(.DW(DW), .LEN_W(LW), .SEL_LIMIT(5)) u_bus_master_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .req_be(req_be),
        .wr_data(wr_data), .wr_idx(wr_idx), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .end_kind(end_kind), .end_count(end_count),
        .req_n_o(req_n_o), .gnt_n_i(gnt_n_i), .frame_n_o(frame_n_o), .frame_oe(frame_oe),
        .irdy_n_o(irdy_n_o), .irdy_oe(irdy_oe), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
        .cbe_o(cbe_o), .cbe_oe(cbe_oe), .trdy_n_i(trdy_n_i), .stop_n_i(stop_n_i),
        .devsel_n_i(devsel_n_i)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] rpat(input int i);
        return 32'h5EED_0100 + 32'(i * 3);
    endfunction

    // scenario settings
    int          s_len = 0, dev_at = 1, stop_at = 99, gdelay = 0;
    logic [31:0] trdy_pat = '0;

    // behavioural reference model
    int          ms = 0, rq = 0, rem = 0, mcnt = 0, dcyc = 0, mkind = 0;
    bit          seen = 0, rv = 0;
    logic [31:0] rd_e = '0;

    always @(posedge clk) begin
        rv = 0;
        if (rst) ms = 0;
        else begin
            case (ms)
                0: if (req_valid) begin ms = 1; rq = 0; end
                1: if (!gnt_n_i) ms = 2; else rq++;
                2: begin
                    ms = 3; rem = (s_len == 0) ? 1 : s_len;
                    mcnt = 0; dcyc = 1; seen = 0;
                end
                3: begin
                    if (!devsel_n_i) seen = 1;
                    if (!trdy_n_i && !req_cmd[0]) begin rv = 1; rd_e = rpat(mcnt); end
                    if (!trdy_n_i) begin mcnt++; rem--; end
                    if (!stop_n_i) begin mkind = (mcnt == 0) ? 1 : 2; ms = 4; end
                    else if (!trdy_n_i && rem == 0) begin mkind = 0; ms = 4; end
                    else if (!seen && dcyc == 5) begin mkind = 3; ms = 4; end
                    else dcyc++;
                end
                default: ms = 0;
            endcase
        end
    end

    // compare on every clock, then drive the target side for the next cycle
    always @(negedge clk) begin
        if (!rst) begin
            chk(req_n_o == (ms != 1), "R2 req_n", req_n_o, ms != 1);
            chk(frame_oe == (ms >= 2), "R3 frame_oe", frame_oe, ms >= 2);
            if (ms >= 2)
                chk(frame_n_o == !(ms == 2 || (ms == 3 && rem != 1)), "R6 frame_n", frame_n_o,
                    !(ms == 2 || (ms == 3 && rem != 1)));
            chk(irdy_oe == (ms == 3 || ms == 4), "R4 irdy_oe", irdy_oe, ms == 3 || ms == 4);
            if (irdy_oe) chk(irdy_n_o == (ms != 3), "R4 irdy_n", irdy_n_o, ms != 3);
            chk(ad_oe == (ms == 2 || (ms == 3 && req_cmd[0])), "R12 ad_oe", ad_oe,
                ms == 2 || (ms == 3 && req_cmd[0]));
            if (ms == 2) chk(ad_o == req_addr, "R3 address", ad_o, req_addr);
            if (ms == 3 && req_cmd[0])
                chk(ad_o == 32'hC0DE_0000 + 32'(mcnt), "R12 write word", ad_o, 32'hC0DE_0000 + 32'(mcnt));
            chk(cbe_oe == (ms == 2 || ms == 3), "R7 cbe_oe", cbe_oe, ms == 2 || ms == 3);
            if (ms == 2) chk(cbe_o == req_cmd, "R3 command", cbe_o, req_cmd);
            if (ms == 3) chk(cbe_o == ~req_be, "R4 byte enables", cbe_o, ~req_be);
            chk(done == (ms == 4), "R7 done", done, ms == 4);
            if (ms == 4) begin
                chk(end_kind == 2'(mkind), "R11 model kind", end_kind, mkind);
                chk(end_count == 8'(mcnt), "R11 model count", end_count, mcnt);
            end
            chk(rd_valid == rv, "R5 rd_valid", rd_valid, rv);
            if (rv) chk(rd_data == rd_e, "R5 rd_data", rd_data, rd_e);
        end
        gnt_n_i    = !(ms == 1 && rq >= gdelay);
        devsel_n_i = !(ms == 3 && dcyc >= dev_at);
        trdy_n_i   = !(ms == 3 && dcyc < 32 && trdy_pat[dcyc]);
        stop_n_i   = !(ms == 3 && dcyc == stop_at);
        ad_i       = rpat(mcnt);
    end

    task automatic run(input logic [3:0] c, input logic [31:0] a, input int len,
                       input logic [3:0] be, input int dv, input logic [31:0] tp,
                       input int sp, input int gd, input int ek, input int ec, input string tag);
        @(negedge clk);
        s_len = len; dev_at = dv; trdy_pat = tp; stop_at = sp; gdelay = gd;
        req_cmd = c; req_addr = a; req_len = 8'(len); req_be = be;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (ms != 4) @(negedge clk);
        chk(end_kind == 2'(ek), {tag, " end kind"}, end_kind, ek);
        chk(end_count == 8'(ec), {tag, " end count"}, end_count, ec);
        @(negedge clk);
        chk(!frame_oe && !irdy_oe && !ad_oe && !cbe_oe, "R7 released", {frame_oe, irdy_oe, ad_oe, cbe_oe}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_n_o && !frame_oe && !irdy_oe && !ad_oe && !cbe_oe && !done && !rd_valid,
            "R1 reset outputs", {req_n_o, frame_oe, irdy_oe, ad_oe, cbe_oe, done, rd_valid}, 7'b1000000);
        rst = 1'b0;
        @(negedge clk);
        chk(req_n_o && !frame_oe && !done, "R1 after reset", {req_n_o, frame_oe, done}, 3'b100);
        // R11 write burst with target waits
        run(4'b0111, 32'h1000_0040, 4, 4'b1111, 1, 32'b1101100, 99, 0, 0, 4, "R11 write burst");
        // R5 read burst, late devsel, waits
        run(4'b0110, 32'h2000_0100, 3, 4'b0011, 2, 32'b110100, 99, 1, 0, 3, "R5 read burst");
        // R6 single word with delayed grant (R2)
        run(4'b0011, 32'h0000_03F8, 1, 4'b0001, 1, 32'b10, 99, 3, 0, 1, "R6 single word");
        // R8 retry
        run(4'b0110, 32'h3000_0000, 4, 4'b1111, 1, 32'b0, 2, 0, 1, 0, "R8 retry");
        // R9 disconnect after two words
        run(4'b0111, 32'h4000_0000, 5, 4'b1100, 1, 32'b110, 3, 0, 2, 2, "R9 disconnect");
        // R9 stop on the edge of the first transfer
        run(4'b0110, 32'h5000_0000, 4, 4'b1111, 1, 32'b10, 1, 0, 2, 1, "R9 stop with data");
        // R10 no device select
        run(4'b1010, 32'h0000_0804, 2, 4'b1111, 99, 32'b0, 99, 0, 3, 0, "R10 master abort");
        // R10 device select in the fifth data cycle is still in time
        run(4'b1011, 32'h0000_0808, 1, 4'b1111, 5, 32'b100000, 99, 0, 0, 1, "R10 late devsel");
        // R11 zero length treated as one word
        run(4'b0111, 32'h6000_0000, 0, 4'b1111, 1, 32'b10, 99, 0, 0, 1, "R11 zero length");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule